// File: doc/BRIEF.md
# SPI Host Register-Side FIFO and Interrupt Front End

This block sits between a simple register bus and the byte streams of a serial shift engine in a programmed-I/O SPI host. Software feeds transmit data into one byte-wide write FIFO. It can push through a single-byte port or through a full-word port, and the two can be mixed freely. The FIFO hands bytes one at a time to the engine over a valid/ready stream. Receive bytes from the engine fill a read FIFO. Software drains that FIFO a word at a time, and each word holds up to four bytes packed from the low end.

Fill levels are reported in bytes. The write side reports its free space. The read side reports its byte count, an empty flag and several threshold flags. A sticky interrupt status register gathers FIFO conditions, the error events (write overrun and read underrun) and a transaction-done pulse from the engine. Each status bit is cleared by writing a one to it. A per-bit enable register gates the single interrupt line.

Top module: `spi_pio_frontend`

## Requirements
- R1: A write to the byte push register (address 2) places bits [7:0] into the write FIFO. A write to the word push register (address 3) places four bytes, and the engine receives bits [7:0] first, then [15:8], [23:16] and [31:24]. Bytes leave on the transmit stream in push order, one per cycle in which tx_valid and tx_ready are both high.
- R2: The write status register (address 4) holds the number of free write-FIFO bytes in bits [31:16], with bits [15:0] zero. The write FIFO holds 64 bytes.
- R3: A push that needs more bytes than are free is dropped entirely, FIFO contents and free count stay unchanged, and interrupt status bit 11 is set.
- R4: The read status register (address 5) holds the byte count in bits [10:4]. Bit 11 is set when the count is zero. Bit 0 is set when the count is at least 4. Bits 1, 2 and 3 are set when the count is at least 16, 32 and 64.
- R5: A read of the read data register (address 6) removes min(count, 4) bytes. The oldest byte is returned in bits [7:0] and the following bytes in the next higher bytes. Byte lanes with no data read as zero.
- R6: A read of the read data register while the read FIFO is empty returns zero and sets interrupt status bit 0.
- R7: A write to the flush register (address 7) with bit 0 set empties the read FIFO. A write with bit 0 clear has no effect.
- R8: Interrupt status (address 1) sets bit 1 while read data is present, bit 2 while at least 4 bytes are present, bit 9 while the write FIFO is empty, bit 10 while it is full, and bit 16 on a xfer_done pulse. Every status bit stays set after its cause disappears.
- R9: Writing a 1 to a status bit clears it, and writing 0 leaves it unchanged. If a setting event falls in the same cycle as the clearing write, the bit stays set.
- R10: irq is high exactly when some status bit and the same bit of the enable register (address 0) are both set. The enable register reads back only the implemented bits 0, 1, 2, 9, 10, 11 and 16.
- R11: After reset both FIFOs are empty, the enable register is zero, irq and tx_valid are low, and status bits other than those driven by a current condition read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read data register pops) |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_rd |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Engine accepts the transmit byte |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Engine offers a received byte |
| rx_ready | output | 1 | Read FIFO has room |
| rx_data | input | 8 | Received byte |
| xfer_done | input | 1 | Transaction-complete pulse from the engine |
| irq | output | 1 | Interrupt request |

## Verification
The collision that matters most is a status-setting event in the same cycle as a software write-one-to-clear of that bit. The bench drives a xfer_done pulse on the same clock edge as a clearing write to bit 16, and requires the bit to read back set afterwards. A later clear with no event must then remove it. A second collision, a word push into a write FIFO that has only three free bytes, is judged by draining the whole FIFO and comparing every byte against the bench's own expected sequence.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

  localparam int REG_AW = 3;
  localparam int IRQ_W  = 17;

  typedef enum logic [REG_AW-1:0] {
    REG_IRQ_EN   = 3'd0,
    REG_IRQ_STAT = 3'd1,
    REG_TX_BYTE  = 3'd2,
    REG_TX_WORD  = 3'd3,
    REG_TX_STAT  = 3'd4,
    REG_RX_STAT  = 3'd5,
    REG_RX_DATA  = 3'd6,
    REG_RX_FLUSH = 3'd7
  } reg_sel_e;

  // interrupt bit positions (software decodes these)
  localparam int IRQ_RX_UNDER  = 0;
  localparam int IRQ_RX_NEMPTY = 1;
  localparam int IRQ_RX_RDY    = 2;
  localparam int IRQ_TX_EMPTY  = 9;
  localparam int IRQ_TX_FULL   = 10;
  localparam int IRQ_TX_OVER   = 11;
  localparam int IRQ_XFER_DONE = 16;

  localparam logic [IRQ_W-1:0] IRQ_IMPL = 17'h10E07;

endpackage

// File: rtl/byte_lane_fifo.sv
module byte_lane_fifo #(
  parameter int DEPTH     = 64,
  parameter int IN_LANES  = 4,
  parameter int OUT_LANES = 1,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1,
  localparam int IW = $clog2(IN_LANES + 1),
  localparam int OW = $clog2(OUT_LANES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic [IW-1:0]          push_cnt,
  input  logic [8*IN_LANES-1:0]  push_data,
  input  logic [OW-1:0]          pop_cnt,
  output logic [8*OUT_LANES-1:0] peek_data,
  output logic [LW-1:0]          level
);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d;
  logic [AW-1:0] rd_ptr_q, rd_ptr_d;
  logic [LW-1:0] level_q, level_d;

  always_comb begin
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      level_d  = '0;
    end else begin
      wr_ptr_d = wr_ptr_q + AW'(push_cnt);
      rd_ptr_d = rd_ptr_q + AW'(pop_cnt);
      level_d  = level_q + LW'(push_cnt) - LW'(pop_cnt);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      level_q  <= level_d;
    end
  end

  // storage carries no reset; lanes beyond push_cnt are not written
  always_ff @(posedge clk) begin
    for (int i = 0; i < IN_LANES; i++) begin
      if (!flush && (IW'(i) < push_cnt)) begin
        mem[wr_ptr_q + AW'(i)] <= push_data[8*i +: 8];
      end
    end
  end

  for (genvar j = 0; j < OUT_LANES; j++) begin : g_peek
    assign peek_data[8*j +: 8] = (LW'(j) < level_q) ? mem[rd_ptr_q + AW'(j)] : 8'h00;
  end

  assign level = level_q;

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q + LW'(push_cnt)) <= LW'(DEPTH));

  a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    LW'(pop_cnt) <= level_q);

  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level_q == '0));

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import spi_fe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_W-1:0] set_evt,
  input  logic [IRQ_W-1:0] clr,
  input  logic             en_we,
  input  logic [IRQ_W-1:0] en_wdata,
  output logic [IRQ_W-1:0] stat,
  output logic [IRQ_W-1:0] en,
  output logic             irq
);

  logic [IRQ_W-1:0] stat_q, stat_d;
  logic [IRQ_W-1:0] en_q, en_d;

  always_comb begin
    stat_d = ((stat_q & ~clr) | set_evt) & IRQ_IMPL;
    en_d   = en_we ? (en_wdata & IRQ_IMPL) : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= stat_d;
      en_q   <= en_d;
    end
  end

  assign stat = stat_q;
  assign en   = en_q;
  assign irq  = |(stat_q & en_q);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q != '0) |=> (((($past(stat_q) & ~$past(clr)) & ~stat_q)) == '0));

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_evt & IRQ_IMPL) != '0) |=>
      ((stat_q & $past(set_evt & IRQ_IMPL)) == $past(set_evt & IRQ_IMPL)));

  a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);

endmodule

// File: rtl/spi_pio_frontend.sv
module spi_pio_frontend
  import spi_fe_pkg::*;
#(
  parameter int TX_DEPTH = 64,
  parameter int RX_DEPTH = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  input  logic              xfer_done,
  output logic              irq
);

  localparam int TX_LW = $clog2(TX_DEPTH) + 1;
  localparam int RX_LW = $clog2(RX_DEPTH) + 1;

  reg_sel_e         sel;
  logic [TX_LW-1:0] tx_level, tx_free;
  logic [RX_LW-1:0] rx_level;
  logic [2:0]       tx_need, tx_push_cnt, rx_pop_cnt;
  logic [31:0]      tx_push_data, rx_word;
  logic             tx_overrun, rx_req, rx_underrun, rx_flush, rx_push;
  logic [31:0]      rx_stat, tx_stat;
  logic [IRQ_W-1:0] irq_set, irq_clr, irq_stat, irq_en;

  assign sel = reg_sel_e'(bus_addr);

  // write side
  always_comb begin
    tx_need      = 3'd0;
    tx_push_data = bus_wdata;
    if (bus_wr && sel == REG_TX_BYTE) begin
      tx_need      = 3'd1;
      tx_push_data = {24'h0, bus_wdata[7:0]};
    end else if (bus_wr && sel == REG_TX_WORD) begin
      tx_need = 3'd4;
    end
  end

  assign tx_free     = TX_LW'(TX_DEPTH) - tx_level;
  assign tx_overrun  = (tx_need != 3'd0) && (TX_LW'(tx_need) > tx_free);
  assign tx_push_cnt = tx_overrun ? 3'd0 : tx_need;
  assign tx_valid    = (tx_level != '0);

  byte_lane_fifo #(.DEPTH(TX_DEPTH), .IN_LANES(4), .OUT_LANES(1)) i_tx_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (1'b0),
    .push_cnt  (tx_push_cnt),
    .push_data (tx_push_data),
    .pop_cnt   (tx_valid && tx_ready),
    .peek_data (tx_data),
    .level     (tx_level)
  );

  // read side
  assign rx_ready    = (32'(rx_level) < RX_DEPTH);
  assign rx_push     = rx_valid && rx_ready;
  assign rx_req      = bus_rd && (sel == REG_RX_DATA);
  assign rx_underrun = rx_req && (rx_level == '0);
  assign rx_flush    = bus_wr && (sel == REG_RX_FLUSH) && bus_wdata[0];
  assign rx_pop_cnt  = !rx_req ? 3'd0 :
                       (32'(rx_level) >= 32'd4) ? 3'd4 : rx_level[2:0];

  byte_lane_fifo #(.DEPTH(RX_DEPTH), .IN_LANES(1), .OUT_LANES(4)) i_rx_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (rx_flush),
    .push_cnt  (rx_push),
    .push_data (rx_data),
    .pop_cnt   (rx_pop_cnt),
    .peek_data (rx_word),
    .level     (rx_level)
  );

  always_comb begin
    rx_stat        = '0;
    rx_stat[0]     = (32'(rx_level) >= 32'd4);
    rx_stat[1]     = (32'(rx_level) >= 32'd16);
    rx_stat[2]     = (32'(rx_level) >= 32'd32);
    rx_stat[3]     = (32'(rx_level) >= 32'd64);
    rx_stat[10:4]  = 7'(rx_level);
    rx_stat[11]    = (rx_level == '0);
    tx_stat        = {16'(tx_free), 16'h0};
  end

  // interrupt sources
  always_comb begin
    irq_set                = '0;
    irq_set[IRQ_RX_UNDER]  = rx_underrun;
    irq_set[IRQ_RX_NEMPTY] = (rx_level != '0);
    irq_set[IRQ_RX_RDY]    = (32'(rx_level) >= 32'd4);
    irq_set[IRQ_TX_EMPTY]  = (tx_level == '0);
    irq_set[IRQ_TX_FULL]   = (32'(tx_level) == TX_DEPTH);
    irq_set[IRQ_TX_OVER]   = tx_overrun;
    irq_set[IRQ_XFER_DONE] = xfer_done;
    irq_clr = (bus_wr && sel == REG_IRQ_STAT) ? bus_wdata[IRQ_W-1:0] : '0;
  end

  irq_ctrl i_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_evt  (irq_set),
    .clr      (irq_clr),
    .en_we    (bus_wr && sel == REG_IRQ_EN),
    .en_wdata (bus_wdata[IRQ_W-1:0]),
    .stat     (irq_stat),
    .en       (irq_en),
    .irq      (irq)
  );

  always_comb begin
    case (sel)
      REG_IRQ_EN:   bus_rdata = 32'(irq_en);
      REG_IRQ_STAT: bus_rdata = 32'(irq_stat);
      REG_TX_STAT:  bus_rdata = tx_stat;
      REG_RX_STAT:  bus_rdata = rx_stat;
      REG_RX_DATA:  bus_rdata = rx_word;
      default:      bus_rdata = 32'h0;
    endcase
  end

  a_r4_ready_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stat[0] |-> !rx_stat[11]);

  a_r6_underrun_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rx_underrun |-> (bus_rdata == 32'h0));

  a_r3_drop_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
    tx_overrun |=> (tx_level <= $past(tx_level)));

endmodule

// File: tb/test_spi_pio_frontend.sv
module test_spi_pio_frontend;

  logic        clk, rst_n;
  logic        bus_wr, bus_rd;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        tx_valid, tx_ready, rx_valid, rx_ready, xfer_done, irq;
  logic [7:0]  tx_data, rx_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  spi_pio_frontend i_spi_pio_frontend (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .xfer_done(xfer_done), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rx_send(logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic tx_take(output logic [7:0] b, output logic v);
    @(negedge clk);
    tx_ready = 1'b1;
    #1 b = tx_data; v = tx_valid;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic clear_stat();
    bus_write(3'd1, 32'hFFFF_FFFF);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R11 tx_valid", {31'h0, tx_valid}, 32'h0);
    check("R11 irq", {31'h0, irq}, 32'h0);
    check("R11 rx_ready", {31'h0, rx_ready}, 32'h1);
    bus_read(3'd4, d); check("R11/R2 tx free", d, 32'h0040_0000);
    bus_read(3'd5, d); check("R11/R4 rx empty", d, 32'h0000_0800);
    bus_read(3'd0, d); check("R11 enable", d, 32'h0);
    bus_read(3'd1, d); check("R11 status only tx-empty", d, 32'h0000_0200);
  endtask

  task automatic t_push_order();
    logic [31:0] d; logic [7:0] b; logic v;
    logic [7:0] exp [5] = '{8'hAB, 8'h11, 8'h22, 8'h33, 8'h44};
    bus_write(3'd2, 32'h1234_56AB);
    bus_write(3'd3, 32'h4433_2211);
    bus_read(3'd4, d); check("R2 free after 5 bytes", d, 32'h003B_0000);
    for (int i = 0; i < 5; i++) begin
      tx_take(b, v);
      check("R1 tx_valid", {31'h0, v}, 32'h1);
      check("R1 byte order", {24'h0, b}, {24'h0, exp[i]});
    end
    check("R1 drained", {31'h0, tx_valid}, 32'h0);
  endtask

  task automatic t_overrun();
    logic [31:0] d; logic [7:0] b; logic v;
    logic [7:0] exp [64];
    clear_stat();
    for (int k = 0; k < 15; k++) begin
      for (int j = 0; j < 4; j++) exp[4*k+j] = 8'(4*k + j + 8'h10);
      bus_write(3'd3, {exp[4*k+3], exp[4*k+2], exp[4*k+1], exp[4*k]});
    end
    exp[60] = 8'hA0; bus_write(3'd2, 32'h0000_00A0);
    bus_read(3'd1, d); check("R3 no overrun yet", d & 32'h800, 32'h0);
    bus_write(3'd3, 32'hDEAD_BEEF);
    bus_read(3'd1, d); check("R3 word overrun flag", d & 32'h800, 32'h800);
    bus_read(3'd4, d); check("R3 free unchanged", d, 32'h0003_0000);
    for (int j = 61; j < 64; j++) begin
      exp[j] = 8'(j + 8'h40);
      bus_write(3'd2, {24'h0, exp[j]});
    end
    bus_read(3'd4, d); check("R2 full free zero", d, 32'h0);
    bus_read(3'd1, d); check("R8 full bit10", d & 32'h400, 32'h400);
    bus_write(3'd1, 32'h800);
    bus_write(3'd2, 32'h0000_0077);
    bus_read(3'd1, d); check("R3 byte overrun flag", d & 32'h800, 32'h800);
    for (int i = 0; i < 64; i++) begin
      tx_take(b, v);
      if (b !== exp[i] || v !== 1'b1) check("R3 drain content", {23'h0, v, b}, {23'h0, 1'b1, exp[i]});
    end
    check("R3 drained exactly 64", {31'h0, tx_valid}, 32'h0);
  endtask

  task automatic t_rx_pack();
    logic [31:0] d;
    for (int i = 0; i < 6; i++) rx_send(8'(8'hC0 + i));
    bus_read(3'd5, d); check("R4 count 6", d, 32'h0000_0061);
    bus_read(3'd6, d); check("R5 full word", d, 32'hC3C2_C1C0);
    bus_read(3'd5, d); check("R4 count 2", d, 32'h0000_0020);
    bus_read(3'd6, d); check("R5 partial word", d, 32'h0000_C5C4);
    bus_read(3'd5, d); check("R4 empty again", d, 32'h0000_0800);
  endtask

  task automatic t_rx_thresh();
    logic [31:0] d;
    for (int i = 0; i < 64; i++) rx_send(8'(i));
    bus_read(3'd5, d); check("R4 count 64", d, 32'h0000_040F);
    check("R4 rx_ready low at full", {31'h0, rx_ready}, 32'h0);
    for (int w = 0; w < 16; w++) begin
      bus_read(3'd6, d);
      if (d !== {8'(4*w+3), 8'(4*w+2), 8'(4*w+1), 8'(4*w)})
        check("R5 word data", d, {8'(4*w+3), 8'(4*w+2), 8'(4*w+1), 8'(4*w)});
      if (w == 7) begin
        bus_read(3'd5, d); check("R4 count 32", d, 32'h0000_0207);
      end
      if (w == 11) begin
        bus_read(3'd5, d); check("R4 count 16", d, 32'h0000_0103);
      end
    end
    bus_read(3'd5, d); check("R4 drained", d, 32'h0000_0800);
  endtask

  task automatic t_underrun();
    logic [31:0] d;
    clear_stat();
    bus_read(3'd1, d); check("R6 underrun clear", d & 32'h1, 32'h0);
    bus_read(3'd6, d); check("R6 empty read zero", d, 32'h0);
    bus_read(3'd1, d); check("R6 underrun set", d & 32'h1, 32'h1);
  endtask

  task automatic t_flush();
    logic [31:0] d;
    for (int i = 0; i < 3; i++) rx_send(8'h5A);
    bus_write(3'd7, 32'hFFFF_FFFE);
    bus_read(3'd5, d); check("R7 bit0 clear no flush", d, 32'h0000_0030);
    bus_write(3'd7, 32'h1);
    bus_read(3'd5, d); check("R7 flushed", d, 32'h0000_0800);
    bus_read(3'd6, d); check("R7 no stale data", d, 32'h0);
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    clear_stat();
    rx_send(8'h99);
    repeat (2) @(negedge clk);
    bus_read(3'd1, d); check("R8 not-empty set", d & 32'h2, 32'h2);
    bus_read(3'd6, d); check("R5 single byte", d, 32'h0000_0099);
    repeat (3) @(negedge clk);
    bus_read(3'd1, d); check("R8 sticky after drain", d & 32'h2, 32'h2);
    bus_write(3'd1, 32'h2);
    @(negedge clk);
    bus_read(3'd1, d); check("R9 cleared by one", d & 32'h2, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    clear_stat();
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'd1; bus_wdata = 32'h0001_0000; xfer_done = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; xfer_done = 1'b0;
    bus_read(3'd1, d); check("R9 set wins same cycle", d & 32'h1_0000, 32'h1_0000);
    bus_write(3'd1, 32'h0);
    bus_read(3'd1, d); check("R9 zero write keeps", d & 32'h1_0000, 32'h1_0000);
    bus_write(3'd1, 32'h0001_0000);
    bus_read(3'd1, d); check("R9 clear without event", d & 32'h1_0000, 32'h0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    clear_stat();
    bus_write(3'd0, 32'h0001_0000);
    check("R10 no irq before event", {31'h0, irq}, 32'h0);
    @(negedge clk); xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0;
    check("R10 irq on enabled bit", {31'h0, irq}, 32'h1);
    bus_write(3'd0, 32'h0000_0001);
    check("R10 irq masked", {31'h0, irq}, 32'h0);
    bus_write(3'd0, 32'hFFFF_FFFF);
    bus_read(3'd0, d); check("R10 enable readback", d, 32'h0001_0E07);
    check("R10 irq with tx-empty enabled", {31'h0, irq}, 32'h1);
    bus_write(3'd0, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    tx_ready = 1'b0; rx_valid = 1'b0; rx_data = '0; xfer_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_push_order();
    t_overrun();
    t_rx_pack();
    t_rx_thresh();
    t_underrun();
    t_flush();
    t_sticky();
    t_collide();
    t_irq();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule